// File: doc/BRIEF.md
# Priority Pin Crossbar

This block connects seventeen internal peripheral signals to a 20-pin general-purpose port. The signals belong to a UART, an SPI port, a two-wire serial bus, two comparator outputs, a system clock output, up to four capture/compare channels and two timer inputs. Software turns on the functions it needs. A combinational priority decoder then hands each enabled function the lowest-numbered eligible pin still free, working through the functions in a fixed order. A pin is eligible when it is digital and not marked as skipped. Every pin the decoder does not claim acts as ordinary port I/O, driven from a software output latch.

For each pin, software chooses analog or digital, push-pull or open-drain, and whether the decoder passes over it. One global bit disables all weak pullups. A second global bit turns the crossbar on. While it is off, every pin is released. The decoder's result can be read back as a mask of claimed pins. Each peripheral input is taken from the pin its function was given. A function that got no pin reads an idle 1.

Top module: `pin_crossbar`

## Requirements
- R1: After reset, all registers read 0, every `pinOe` bit is 0 and every `funcIn` bit is 1.
- R2: While CTRL bit 0 (crossbar on) is 0, every `pinOe` bit is 0, every `funcIn` bit is 1 and the claim mask (address 6) reads 0.
- R3: Function indices in priority order, highest first: 0 UART TX, 1 UART RX, 2 SPI SCK, 3 SPI MISO, 4 SPI MOSI, 5 SPI NSS, 6 SDA, 7 SCL, 8 CMP0, 9 CMP1, 10 SYSCLK, 11..14 capture channels 0..3, 15 T0, 16 T1. The n-th enabled function, counting from 0, takes the n-th eligible pin, counting upward from pin 0. The pin's output value is then `funcOut` of that function, and its output enable is `funcOe` of that function.
- R4: A pin whose bit is set in the skip register (address 1) is never claimed. It drives its latch bit (address 4), like any unclaimed pin.
- R5: A pin whose bit is set in the analog register (address 2) is never claimed and never driven. Its bit reads 0 in the pin input register (address 5), and its pullup is off.
- R6: CTRL enables are: bit 2 UART, bit 3 SPI, bit 4 serial bus, bit 5 CMP0, bit 6 CMP1, bit 7 SYSCLK, bits 10:8 number of capture channels (values above 4 act as 4), bit 11 T0, bit 12 T1. Disabled functions claim no pin.
- R7: When enabled functions outnumber eligible pins, the lowest-priority functions get no pin, and their `funcIn` reads 1.
- R8: A pin with its bit set in the open-drain register (address 3) never drives a 1. A value of 1 releases it, and a value of 0 is driven actively.
- R9: CTRL bit 1 set turns off every pullup. When it is clear, `pinPullEn` is 1 on every digital pin.
- R10: `funcIn` of a claimed function equals the digital input of its pin.
- R11: Register writes land on the next clock edge. Address 5 reads the digital pin inputs, and address 6 reads the mask of claimed pins.
- R12: An unclaimed digital push-pull pin drives its latch bit with `pinOe` at 1 while the crossbar is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWdata | input | 20 | Register write data |
| regRdata | output | 20 | Register read data (combinational) |
| funcOut | input | 17 | Output value of each peripheral function |
| funcOe | input | 17 | Output enable of each peripheral function |
| funcIn | output | 17 | Input value routed back to each function |
| pinIn | input | 20 | Pad input values |
| pinOut | output | 20 | Pad output values |
| pinOe | output | 20 | Pad output enables |
| pinPullEn | output | 20 | Pad weak pullup enables |

## Verification
The decoder is purely combinational, so any error in a rank or slot count shows up in the same cycle a configuration write lands. It appears as a shifted claim mask at address 6, as a peripheral value on the wrong pin, or as a peripheral input taken from the wrong pad. An error in a configuration register shows one edge after the write. It appears either as a mismatched readback or as `pinOe` asserted where an analog pin, an open-drain 1 or a disabled crossbar forbids it. The directed scenarios use skip holes, analog holes, clamped channel counts and overflow, so that any error in rank or slot counting moves a function to a pin the bench can see.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int NUM_PINS = 20;
  localparam int NUM_FUNC = 17;
  localparam int NUM_CAP  = 4;
  localparam int CAP_BASE = 11;
  localparam int CTRL_W   = 13;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = NUM_PINS;
  localparam int FIDX_W   = $clog2(NUM_FUNC);
  localparam int PIDX_W   = $clog2(NUM_PINS);
  localparam int CNT_W    = $clog2(NUM_PINS + 1);

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_SKIP   = 3'd1;
  localparam logic [ADDR_W-1:0] A_ANALOG = 3'd2;
  localparam logic [ADDR_W-1:0] A_ODRAIN = 3'd3;
  localparam logic [ADDR_W-1:0] A_LATCH  = 3'd4;
  localparam logic [ADDR_W-1:0] A_PINS   = 3'd5;
  localparam logic [ADDR_W-1:0] A_CLAIM  = 3'd6;

  typedef struct packed {
    logic                xbarEn;
    logic                pullDis;
    logic [NUM_FUNC-1:0] funcReq;
    logic [NUM_PINS-1:0] skip;
    logic [NUM_PINS-1:0] analog;
    logic [NUM_PINS-1:0] openDrain;
    logic [NUM_PINS-1:0] latch;
  } cfg_t;
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode
  import xbar_pkg::*;
(
  input  logic [NUM_FUNC-1:0]             funcReq,
  input  logic [NUM_PINS-1:0]             eligible,
  output logic [NUM_PINS-1:0]             pinHit,
  output logic [NUM_PINS-1:0][FIDX_W-1:0] pinFunc,
  output logic [NUM_FUNC-1:0]             funcHit,
  output logic [NUM_FUNC-1:0][PIDX_W-1:0] funcPin
);
  logic [NUM_FUNC-1:0][CNT_W-1:0] fRank;
  logic [NUM_PINS-1:0][CNT_W-1:0] pSlot;

  // rank of each requested function and slot of each eligible pin
  always_comb begin
    logic [CNT_W-1:0] acc;
    acc = '0;
    for (int f = 0; f < NUM_FUNC; f++) begin
      fRank[f] = acc;
      acc = acc + CNT_W'(funcReq[f]);
    end
    acc = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      pSlot[p] = acc;
      acc = acc + CNT_W'(eligible[p]);
    end
  end

  // a function meets a pin when its rank equals the pin's slot
  always_comb begin
    pinHit  = '0;
    pinFunc = '0;
    funcHit = '0;
    funcPin = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      for (int f = 0; f < NUM_FUNC; f++) begin
        if (eligible[p] && funcReq[f] && pSlot[p] == fRank[f]) begin
          pinHit[p]  = 1'b1;
          pinFunc[p] = FIDX_W'(f);
          funcHit[f] = 1'b1;
          funcPin[f] = PIDX_W'(p);
        end
      end
    end
  end
endmodule

// File: rtl/xbar_regs.sv
module xbar_regs
  import xbar_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_PINS-1:0] pinDigIn,
  input  logic [NUM_PINS-1:0] claimMask,
  output cfg_t                cfg
);
  logic [CTRL_W-1:0]   ctrlReg;
  logic [NUM_PINS-1:0] skipReg, analogReg, odReg, latchReg;
  logic [2:0]          capCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      skipReg   <= '0;
      analogReg <= '0;
      odReg     <= '0;
      latchReg  <= '0;
    end else if (regWe) begin
      case (regAddr)
        A_CTRL:   ctrlReg   <= regWdata[CTRL_W-1:0];
        A_SKIP:   skipReg   <= regWdata[NUM_PINS-1:0];
        A_ANALOG: analogReg <= regWdata[NUM_PINS-1:0];
        A_ODRAIN: odReg     <= regWdata[NUM_PINS-1:0];
        A_LATCH:  latchReg  <= regWdata[NUM_PINS-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    capCnt = (ctrlReg[10:8] > 3'(NUM_CAP)) ? 3'(NUM_CAP) : ctrlReg[10:8];
    cfg.xbarEn     = ctrlReg[0];
    cfg.pullDis    = ctrlReg[1];
    cfg.funcReq    = '0;
    cfg.funcReq[1:0] = {2{ctrlReg[2]}};
    cfg.funcReq[5:2] = {4{ctrlReg[3]}};
    cfg.funcReq[7:6] = {2{ctrlReg[4]}};
    cfg.funcReq[8]   = ctrlReg[5];
    cfg.funcReq[9]   = ctrlReg[6];
    cfg.funcReq[10]  = ctrlReg[7];
    for (int i = 0; i < NUM_CAP; i++)
      cfg.funcReq[CAP_BASE+i] = (capCnt > 3'(i));
    cfg.funcReq[15]  = ctrlReg[11];
    cfg.funcReq[16]  = ctrlReg[12];
    cfg.skip      = skipReg;
    cfg.analog    = analogReg;
    cfg.openDrain = odReg;
    cfg.latch     = latchReg;
  end

  always_comb begin
    case (regAddr)
      A_CTRL:   regRdata = DATA_W'(ctrlReg);
      A_SKIP:   regRdata = skipReg;
      A_ANALOG: regRdata = analogReg;
      A_ODRAIN: regRdata = odReg;
      A_LATCH:  regRdata = latchReg;
      A_PINS:   regRdata = pinDigIn;
      A_CLAIM:  regRdata = claimMask;
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/xbar_route.sv
module xbar_route
  import xbar_pkg::*;
(
  input  cfg_t                cfg,
  input  logic [NUM_FUNC-1:0] funcOut,
  input  logic [NUM_FUNC-1:0] funcOe,
  output logic [NUM_FUNC-1:0] funcIn,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinPullEn,
  output logic [NUM_PINS-1:0] pinDigIn,
  output logic [NUM_PINS-1:0] claimMask
);
  logic [NUM_PINS-1:0]             eligible;
  logic [NUM_PINS-1:0][FIDX_W-1:0] pinFunc;
  logic [NUM_FUNC-1:0]             funcHit;
  logic [NUM_FUNC-1:0][PIDX_W-1:0] funcPin;
  logic [NUM_PINS-1:0]             drvEn;

  assign eligible  = {NUM_PINS{cfg.xbarEn}} & ~cfg.skip & ~cfg.analog;
  assign pinDigIn  = pinIn & ~cfg.analog;
  assign pinPullEn = {NUM_PINS{~cfg.pullDis}} & ~cfg.analog;

  xbar_decode u_dec (
    .funcReq (cfg.funcReq),
    .eligible(eligible),
    .pinHit  (claimMask),
    .pinFunc (pinFunc),
    .funcHit (funcHit),
    .funcPin (funcPin)
  );

  always_comb begin
    for (int p = 0; p < NUM_PINS; p++) begin
      if (claimMask[p]) begin
        pinOut[p] = funcOut[pinFunc[p]];
        drvEn[p]  = funcOe[pinFunc[p]];
      end else begin
        pinOut[p] = cfg.latch[p];
        drvEn[p]  = 1'b1;
      end
      pinOe[p] = cfg.xbarEn & ~cfg.analog[p] & drvEn[p]
               & ~(cfg.openDrain[p] & pinOut[p]);
    end
    for (int f = 0; f < NUM_FUNC; f++)
      funcIn[f] = funcHit[f] ? pinDigIn[funcPin[f]] : 1'b1;
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import xbar_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWe,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W-1:0]   regRdata,
  input  logic [NUM_FUNC-1:0] funcOut,
  input  logic [NUM_FUNC-1:0] funcOe,
  output logic [NUM_FUNC-1:0] funcIn,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinPullEn
);
  cfg_t                cfg;
  logic [NUM_PINS-1:0] pinDigIn;
  logic [NUM_PINS-1:0] claimMask;

  xbar_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pinDigIn (pinDigIn),
    .claimMask(claimMask),
    .cfg      (cfg)
  );

  xbar_route u_route (
    .cfg      (cfg),
    .funcOut  (funcOut),
    .funcOe   (funcOe),
    .funcIn   (funcIn),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .pinPullEn(pinPullEn),
    .pinDigIn (pinDigIn),
    .claimMask(claimMask)
  );
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker
  import xbar_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                xbarEn,
  input logic [NUM_FUNC-1:0] funcReq,
  input logic [NUM_PINS-1:0] skip,
  input logic [NUM_PINS-1:0] analog,
  input logic [NUM_PINS-1:0] openDrain,
  input logic                regWe,
  input logic [ADDR_W-1:0]   regAddr,
  input logic [DATA_W-1:0]   regWdata,
  input logic [NUM_PINS-1:0] pinOut,
  input logic [NUM_PINS-1:0] pinOe,
  input logic [NUM_PINS-1:0] claimMask
);
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    !xbarEn |-> (pinOe == '0 && claimMask == '0)); // R2
  AST_ANALOG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & analog) == '0 && (claimMask & analog) == '0)); // R5
  AST_SKIP_UNCLAIMED: assert property (@(posedge clk) disable iff (!rstN)
    ((claimMask & skip) == '0)); // R4
  AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & openDrain & pinOut) == '0)); // R8
  AST_CLAIM_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(claimMask) <= $countones(funcReq))); // R7
  AST_SKIP_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == A_SKIP) |=> (skip == $past(regWdata))); // R11
endmodule

bind pin_crossbar xbar_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .xbarEn   (cfg.xbarEn),
  .funcReq  (cfg.funcReq),
  .skip     (cfg.skip),
  .analog   (cfg.analog),
  .openDrain(cfg.openDrain),
  .regWe    (regWe),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .pinOut   (pinOut),
  .pinOe    (pinOe),
  .claimMask(claimMask)
);

// File: tb/sim_pin_crossbar.sv
`timescale 1ns/1ps
module sim_pin_crossbar;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [19:0] regWdata = '0;
  logic [19:0] regRdata;
  logic [16:0] funcOut = '0;
  logic [16:0] funcOe = '0;
  logic [16:0] funcIn;
  logic [19:0] pinIn = '1;
  logic [19:0] pinOut, pinOe, pinPullEn;
  int nChecks = 0;
  int nErrors = 0;

  always #4 clk = ~clk;

  pin_crossbar u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [19:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [19:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic setup(input logic [19:0] ctrl, input logic [19:0] skip,
                       input logic [19:0] ana, input logic [19:0] od,
                       input logic [19:0] lat);
    wr(3'd0, 20'h0);
    wr(3'd1, skip);
    wr(3'd2, ana);
    wr(3'd3, od);
    wr(3'd4, lat);
    wr(3'd0, ctrl);
  endtask

  task automatic t_reset();
    logic [19:0] d;
    chk("R1 pinOe", 32'(pinOe), 32'h0);
    chk("R1 funcIn", 32'(funcIn), 32'h1FFFF);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1 reg", 32'(d), 32'h0);
    end
  endtask

  task automatic t_uart();
    logic [19:0] d;
    funcOut = 17'h1; funcOe = 17'h1; pinIn = 20'hFFFFD;
    setup(20'h5, 20'h0, 20'h0, 20'h0, 20'h0);
    rd(3'd6, d);
    chk("R3 claim uart", 32'(d), 32'h3);
    chk("R3 tx on pin0", 32'(pinOut[0]), 32'h1);
    chk("R12 oe map", 32'(pinOe), 32'hFFFFD);
    chk("R10 rx from pin1", 32'(funcIn[1]), 32'h0);
    chk("R12 gpio out", 32'(pinOut[19:2]), 32'h0);
    pinIn = '1;
  endtask

  task automatic t_skip();
    logic [19:0] d;
    funcOut = '0; funcOe = '0;
    setup(20'hD, 20'hA, 20'h0, 20'h0, 20'h2);
    rd(3'd6, d);
    chk("R4 claim with skips", 32'(d), 32'hF5);
    chk("R4 skipped pin drives latch", 32'({pinOe[1], pinOut[1]}), 32'h3);
    pinIn = 20'hFFFDF;
    #1;
    chk("R10 miso from pin5", 32'(funcIn[3]), 32'h0);
    pinIn = '1;
    rd(3'd1, d);
    chk("R11 skip readback", 32'(d), 32'hA);
  endtask

  task automatic t_analog();
    logic [19:0] d;
    setup(20'h5, 20'h0, 20'h1, 20'h0, 20'h1);
    rd(3'd6, d);
    chk("R5 analog hole", 32'(d), 32'h6);
    chk("R5 analog oe", 32'(pinOe[0]), 32'h0);
    rd(3'd5, d);
    chk("R5 pin read", 32'(d), 32'hFFFFE);
    chk("R5 pullup off", 32'(pinPullEn), 32'hFFFFE);
    pinIn = 20'hFFFFB;
    #1;
    chk("R10 rx from pin2", 32'(funcIn[1]), 32'h0);
    pinIn = '1;
  endtask

  task automatic t_capture();
    logic [19:0] d;
    funcOut = 17'h1000; funcOe = 17'h1000;
    setup(20'h1201, 20'h0, 20'h0, 20'h0, 20'h0);
    rd(3'd6, d);
    chk("R6 two channels plus T1", 32'(d), 32'h7);
    chk("R6 cex1 on pin1", 32'({pinOe[1], pinOut[1]}), 32'h3);
    setup(20'hF01, 20'h0, 20'h0, 20'h0, 20'h0);
    rd(3'd6, d);
    chk("R6 count clamped", 32'(d), 32'h1F);
    pinIn = 20'hFFFEF;
    #1;
    chk("R10 T0 from pin4", 32'(funcIn[15]), 32'h0);
    pinIn = '1; funcOut = '0; funcOe = '0;
  endtask

  task automatic t_overflow();
    logic [19:0] d;
    setup(20'h1CFD, 20'hFFFF0, 20'h0, 20'h0, 20'h0);
    pinIn = '0;
    rd(3'd6, d);
    chk("R7 only four claimed", 32'(d), 32'hF);
    chk("R7 idle inputs", 32'(funcIn), 32'h1FFF0);
    pinIn = '1;
  endtask

  task automatic t_opendrain();
    funcOut = 17'h1; funcOe = 17'h1;
    setup(20'h5, 20'h0, 20'h0, 20'hFFFFF, 20'h20);
    chk("R8 od releases ones", 32'(pinOe), 32'hFFFDC);
    funcOut = 17'h0;
    #1;
    chk("R8 od drives zero", 32'({pinOe[0], pinOut[0]}), 32'h2);
    funcOut = '0; funcOe = '0;
  endtask

  task automatic t_pull();
    setup(20'h3, 20'h0, 20'h0, 20'h0, 20'h0);
    chk("R9 pullups off", 32'(pinPullEn), 32'h0);
    setup(20'h1, 20'h0, 20'h0, 20'h0, 20'h0);
    chk("R9 pullups on", 32'(pinPullEn), 32'hFFFFF);
  endtask

  task automatic t_off();
    logic [19:0] d;
    funcOut = '1; funcOe = '1; pinIn = '0;
    setup(20'h1DFC, 20'h0, 20'h0, 20'h0, 20'hFFFFF);
    chk("R2 released", 32'(pinOe), 32'h0);
    chk("R2 idle inputs", 32'(funcIn), 32'h1FFFF);
    rd(3'd6, d);
    chk("R2 no claims", 32'(d), 32'h0);
    funcOut = '0; funcOe = '0; pinIn = '1;
  endtask

  initial begin
    #(8 * 200000);
    nErrors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_uart();
    t_skip();
    t_analog();
    t_capture();
    t_overflow();
    t_opendrain();
    t_pull();
    t_off();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule